// File: doc/BRIEF.md
# LED Driver Operating-Mode Controller

This block decides which of four operating modes a multi-channel LED driver is in: init, active, fail-safe or fail-off. Each cycle it takes the events that an external serial-bus decoder has already recognised, together with fault flags, supply comparator levels and a watchdog-expiry strobe. From these it moves a single registered mode state. The mode drives a global output-off line, a tristate enable for the bus pins, and a per-channel strobe. That strobe tells the channel logic to reload its stored fail-safe duty and current presets.

All event inputs are single-cycle strobes and all condition inputs are levels, both sampled on the rising clock edge. The mode changes at the edge that samples the cause. There is no data stream and so no handshake: every pin is a plain control or status line. Fail-off is a latched condition. Once the device is there, only a supply undervoltage brings it back to init, which models a full power cycle. A fault can also leave the device in init rather than fail-off. That happens when the serial bus or the error pin can still report it.

Top module: `ledm_mode_ctrl`

## Requirements
- R1: After asynchronous reset the mode is init (code 0), `out_off_o` is 1, `bus_hiz_o` is 0 and no preset strobe is raised.
- R2: In active mode, an internal fault while the bus or the error pin is still alive moves the mode to init at the next edge.
- R3: From init, active or fail-safe, any of these moves the mode to init: supply undervoltage, an enter-init command, or a sixth consecutive sync break.
- R4: In active mode, a load fault or the error pin being pulled low moves the mode to init.
- R5: Fail-safe (code 2) is entered on any of these: an enter-fail-safe command, a watchdog expiry while in init or active, or an input-pin warning while the watchdog is disabled.
- R6: From fail-safe, a duty-cycle update frame or a warning-clear frame moves the mode to active when the R7 qualifiers hold. An enter-init command moves it to init.
- R7: Active (code 1) is entered from init or fail-safe only when all of these hold in the same cycle: self-test passed, the configuration is locked or emulation is valid, the logic supply is above its rising level, the main supply is above its minimum, and a duty-cycle update or activation request is present.
- R8: `fs_load_o` carries the fail-safe enable mask for exactly one cycle, the first cycle in fail-safe. It is zero at all other times, including a repeated fail-safe trigger while already in fail-safe.
- R9: Sync breaks are counted. Any other valid frame clears the count. The sixth consecutive break issues one reset request, and the count then saturates, so further breaks issue no request until the count is cleared.
- R10: When causes coincide, fail-off beats the init causes, the init causes beat fail-safe, and fail-safe beats active.
- R11: An internal fault with both the bus and the error pin dead moves any non-fail-off mode to fail-off (code 3). In fail-off, every input except undervoltage is ignored, and undervoltage returns the mode to init.
- R12: `out_off_o` is 1 in init and fail-off and 0 otherwise. `bus_hiz_o` is 1 only in fail-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_init_i | input | 1 | Enter-init command frame strobe |
| cmd_safe_i | input | 1 | Enter-fail-safe command frame strobe |
| dc_upd_i | input | 1 | Duty-cycle update frame strobe |
| warn_clr_i | input | 1 | Warning-clear frame strobe |
| other_frame_i | input | 1 | Any other valid frame strobe |
| sync_brk_i | input | 1 | Sync-break frame strobe |
| int_fault_i | input | 1 | Internal fault flag |
| bus_alive_i | input | 1 | Serial bus still operational |
| errpin_alive_i | input | 1 | Error pin still operational |
| load_fault_i | input | 1 | Load fault detected |
| errpin_low_i | input | 1 | Error pin pulled active below threshold |
| vdd_uv_i | input | 1 | Logic supply below falling threshold |
| vdd_up_i | input | 1 | Logic supply above rising threshold |
| vs_ok_i | input | 1 | Main supply above minimum |
| wdt_exp_i | input | 1 | Watchdog timeout strobe |
| wdt_off_i | input | 1 | Watchdog disabled |
| pin_warn_i | input | 1 | Input-pin warning |
| pin_act_i | input | 1 | Input-pin activation request |
| bist_ok_i | input | 1 | Built-in self-tests passed |
| cfg_lock_i | input | 1 | Configuration locked |
| emu_ok_i | input | 1 | Configuration emulation valid |
| safe_en_i | input | NCH | Channels enabled in fail-safe |
| mode_o | output | 2 | Mode code: 0 init, 1 active, 2 fail-safe, 3 fail-off |
| out_off_o | output | 1 | Global output-off |
| bus_hiz_o | output | 1 | Bus pin tristate enable |
| fs_load_o | output | NCH | Per-channel fail-safe preset load strobe |

## Verification
The hardest state to reach is a saturated sync-break counter observed outside init. Six breaks move the device out of active, so the bench returns to active with a pin activation request, which is not a frame and leaves the count alone. A seventh break must then leave active untouched. Fail-off is equally awkward: the bench kills both reporting paths at the moment of the fault. While in fail-off it replays every exit that would work elsewhere, including six fresh breaks, before undervoltage finally releases the device.

// File: rtl/ledm_pkg.sv
package ledm_pkg;
  typedef enum logic [1:0] {
    MODE_INIT   = 2'd0,
    MODE_ACTIVE = 2'd1,
    MODE_SAFE   = 2'd2,
    MODE_OFF    = 2'd3
  } ledm_mode_e;
endpackage

// File: rtl/ledm_brk_cnt.sv
module ledm_brk_cnt #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic req_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (hold_i || clr_i)        cnt_q <= '0;
    else if (brk_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign req_o = brk_i && !clr_i && !hold_i && (cnt_q == LAST);

  // R9
  brk_single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R9
  brk_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
endmodule

// File: rtl/ledm_mode_fsm.sv
module ledm_mode_fsm
  import ledm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_init_i,
  input  logic       cmd_safe_i,
  input  logic       dc_upd_i,
  input  logic       warn_clr_i,
  input  logic       brk_req_i,
  input  logic       int_fault_i,
  input  logic       bus_alive_i,
  input  logic       errpin_alive_i,
  input  logic       load_fault_i,
  input  logic       errpin_low_i,
  input  logic       vdd_uv_i,
  input  logic       vdd_up_i,
  input  logic       vs_ok_i,
  input  logic       wdt_exp_i,
  input  logic       wdt_off_i,
  input  logic       pin_warn_i,
  input  logic       pin_act_i,
  input  logic       bist_ok_i,
  input  logic       cfg_lock_i,
  input  logic       emu_ok_i,
  output ledm_mode_e state_q,
  output ledm_mode_e state_nxt
);
  logic fault_dead, go_init, act_init, go_safe, qual, trig;

  always_comb begin
    fault_dead = int_fault_i && !bus_alive_i && !errpin_alive_i;
    go_init    = vdd_uv_i || cmd_init_i || brk_req_i;
    act_init   = (state_q == MODE_ACTIVE) &&
                 (load_fault_i || errpin_low_i ||
                  (int_fault_i && (bus_alive_i || errpin_alive_i)));
    go_safe    = cmd_safe_i || (pin_warn_i && wdt_off_i) ||
                 (wdt_exp_i && (state_q == MODE_INIT || state_q == MODE_ACTIVE));
    qual       = bist_ok_i && (cfg_lock_i || emu_ok_i) && vdd_up_i && vs_ok_i;
    trig       = dc_upd_i || pin_act_i || (state_q == MODE_SAFE && warn_clr_i);

    state_nxt = state_q;
    if (state_q == MODE_OFF) begin
      if (vdd_uv_i) state_nxt = MODE_INIT;
    end else if (fault_dead) begin
      state_nxt = MODE_OFF;
    end else if (go_init || act_init) begin
      state_nxt = MODE_INIT;
    end else if (go_safe) begin
      state_nxt = MODE_SAFE;
    end else if (state_q != MODE_ACTIVE && qual && trig) begin
      state_nxt = MODE_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_INIT;
    else        state_q <= state_nxt;
  end

  // R11
  off_exit_only_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_OFF) |=> (state_q == MODE_OFF || state_q == MODE_INIT));

  // R11
  off_exit_needs_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == MODE_OFF && state_q == MODE_INIT) |-> $past(vdd_uv_i));

  // R3
  uv_forces_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != MODE_OFF && vdd_uv_i && !(int_fault_i && !bus_alive_i && !errpin_alive_i))
      |=> state_q == MODE_INIT);

  // R7
  active_entry_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_ACTIVE && $past(state_q) != MODE_ACTIVE)
      |-> $past(bist_ok_i && vdd_up_i && vs_ok_i && (cfg_lock_i || emu_ok_i)));
endmodule

// File: rtl/ledm_out_stage.sv
module ledm_out_stage
  import ledm_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ledm_mode_e     state_q,
  input  ledm_mode_e     state_nxt,
  input  logic [NCH-1:0] safe_en_i,
  output logic           out_off_o,
  output logic           bus_hiz_o,
  output logic [NCH-1:0] fs_load_o
);
  logic enter_safe;
  assign enter_safe = (state_nxt == MODE_SAFE) && (state_q != MODE_SAFE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic load_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b0;
      else        load_q <= enter_safe && safe_en_i[c];
    end
    assign fs_load_o[c] = load_q;
  end

  assign out_off_o = (state_q == MODE_INIT) || (state_q == MODE_OFF);
  assign bus_hiz_o = (state_q == MODE_OFF);

  // R8
  load_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fs_load_o) |-> (state_q == MODE_SAFE && $past(state_q) != MODE_SAFE));

  // R8
  load_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fs_load_o) |=> !(|fs_load_o));
endmodule

// File: rtl/ledm_mode_ctrl.sv
module ledm_mode_ctrl
  import ledm_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int BRK_LIMIT = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_init_i,
  input  logic           cmd_safe_i,
  input  logic           dc_upd_i,
  input  logic           warn_clr_i,
  input  logic           other_frame_i,
  input  logic           sync_brk_i,
  input  logic           int_fault_i,
  input  logic           bus_alive_i,
  input  logic           errpin_alive_i,
  input  logic           load_fault_i,
  input  logic           errpin_low_i,
  input  logic           vdd_uv_i,
  input  logic           vdd_up_i,
  input  logic           vs_ok_i,
  input  logic           wdt_exp_i,
  input  logic           wdt_off_i,
  input  logic           pin_warn_i,
  input  logic           pin_act_i,
  input  logic           bist_ok_i,
  input  logic           cfg_lock_i,
  input  logic           emu_ok_i,
  input  logic [NCH-1:0] safe_en_i,
  output logic [1:0]     mode_o,
  output logic           out_off_o,
  output logic           bus_hiz_o,
  output logic [NCH-1:0] fs_load_o
);
  ledm_mode_e state_q, state_nxt;
  logic       brk_req, frame_clr;

  assign frame_clr = other_frame_i || cmd_init_i || cmd_safe_i || dc_upd_i || warn_clr_i;

  ledm_brk_cnt #(.LIMIT(BRK_LIMIT)) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .brk_i  (sync_brk_i),
    .clr_i  (frame_clr),
    .hold_i (state_q == MODE_OFF),
    .req_o  (brk_req)
  );

  ledm_mode_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_init_i     (cmd_init_i),
    .cmd_safe_i     (cmd_safe_i),
    .dc_upd_i       (dc_upd_i),
    .warn_clr_i     (warn_clr_i),
    .brk_req_i      (brk_req),
    .int_fault_i    (int_fault_i),
    .bus_alive_i    (bus_alive_i),
    .errpin_alive_i (errpin_alive_i),
    .load_fault_i   (load_fault_i),
    .errpin_low_i   (errpin_low_i),
    .vdd_uv_i       (vdd_uv_i),
    .vdd_up_i       (vdd_up_i),
    .vs_ok_i        (vs_ok_i),
    .wdt_exp_i      (wdt_exp_i),
    .wdt_off_i      (wdt_off_i),
    .pin_warn_i     (pin_warn_i),
    .pin_act_i      (pin_act_i),
    .bist_ok_i      (bist_ok_i),
    .cfg_lock_i     (cfg_lock_i),
    .emu_ok_i       (emu_ok_i),
    .state_q        (state_q),
    .state_nxt      (state_nxt)
  );

  ledm_out_stage #(.NCH(NCH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .safe_en_i (safe_en_i),
    .out_off_o (out_off_o),
    .bus_hiz_o (bus_hiz_o),
    .fs_load_o (fs_load_o)
  );

  assign mode_o = state_q;

  // R12
  hiz_implies_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hiz_o |-> out_off_o);
endmodule

// File: tb/ledm_mode_ctrl_bench.sv
`timescale 1ns/1ps
module ledm_mode_ctrl_bench;
  localparam int NCH = 8;
  localparam logic [NCH-1:0] FS_EN = 8'hA5;
  localparam logic [1:0] MI = 2'd0, MA = 2'd1, MS = 2'd2, MO = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_init, cmd_safe, dc_upd, warn_clr, other_frame, sync_brk;
  logic int_fault, bus_alive, err_alive, load_fault, errpin_low;
  logic vdd_uv, vdd_up, vs_ok, wdt_exp, wdt_off, pin_warn, pin_act;
  logic bist_ok, cfg_lock, emu_ok;
  logic [1:0] mode;
  logic out_off, bus_hiz;
  logic [NCH-1:0] fs_load;

  always #2.5 clk = ~clk;

  ledm_mode_ctrl #(.NCH(NCH)) u_ledm_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_init_i(cmd_init), .cmd_safe_i(cmd_safe),
    .dc_upd_i(dc_upd), .warn_clr_i(warn_clr), .other_frame_i(other_frame),
    .sync_brk_i(sync_brk), .int_fault_i(int_fault), .bus_alive_i(bus_alive),
    .errpin_alive_i(err_alive), .load_fault_i(load_fault), .errpin_low_i(errpin_low),
    .vdd_uv_i(vdd_uv), .vdd_up_i(vdd_up), .vs_ok_i(vs_ok), .wdt_exp_i(wdt_exp),
    .wdt_off_i(wdt_off), .pin_warn_i(pin_warn), .pin_act_i(pin_act),
    .bist_ok_i(bist_ok), .cfg_lock_i(cfg_lock), .emu_ok_i(emu_ok),
    .safe_en_i(FS_EN), .mode_o(mode), .out_off_o(out_off), .bus_hiz_o(bus_hiz),
    .fs_load_o(fs_load)
  );

  typedef struct {
    logic [1:0]     mode;
    logic [NCH-1:0] load;
    string          tag;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  // monitor: pops one expected item per cycle, after the edge that produced it
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      if (q.size() > 0) begin
        exp_t e;
        logic exp_off, exp_hiz;
        e = q.pop_front();
        exp_off = (e.mode == MI) || (e.mode == MO);   // R12
        exp_hiz = (e.mode == MO);                     // R12
        n_chk++;
        if (mode !== e.mode || out_off !== exp_off || bus_hiz !== exp_hiz || fs_load !== e.load) begin
          n_err++;
          $display("FAIL %s: mode=%0d off=%0b hiz=%0b load=%h expected mode=%0d off=%0b hiz=%0b load=%h",
                   e.tag, mode, out_off, bus_hiz, fs_load, e.mode, exp_off, exp_hiz, e.load);
        end
      end
    end
  end

  task automatic clr_pulses();
    cmd_init = 0; cmd_safe = 0; dc_upd = 0; warn_clr = 0; other_frame = 0;
    sync_brk = 0; int_fault = 0; load_fault = 0; errpin_low = 0; vdd_uv = 0;
    wdt_exp = 0; pin_warn = 0; pin_act = 0;
  endtask

  // driver: inputs already set at negedge; push expectation for this edge
  task automatic cyc(input logic [1:0] m, input bit ld, input string tag);
    exp_t e;
    @(posedge clk);
    e.mode = m; e.load = ld ? FS_EN : '0; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    clr_pulses();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    clr_pulses();
    bus_alive = 1; err_alive = 1; vdd_up = 1; vs_ok = 1; wdt_off = 0;
    bist_ok = 1; cfg_lock = 1; emu_ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cyc(MI, 0, "R1 reset state");
    dc_upd = 1;     cyc(MA, 0, "R7 dc update enters active");
    load_fault = 1; cyc(MI, 0, "R4 load fault");
    dc_upd = 1;     cyc(MA, 0, "R7");
    errpin_low = 1; cyc(MI, 0, "R4 error pin low");
    dc_upd = 1;     cyc(MA, 0, "R7");
    err_alive = 0; int_fault = 1; cyc(MI, 0, "R2 fault with bus alive");
    err_alive = 1;
    dc_upd = 1;     cyc(MA, 0, "R7");
    wdt_exp = 1;    cyc(MS, 1, "R5 R8 watchdog to fail-safe");
    cyc(MS, 0, "R8 strobe one cycle");
    wdt_exp = 1;    cyc(MS, 0, "R8 no strobe while in fail-safe");
    bist_ok = 0; warn_clr = 1; cyc(MS, 0, "R7 unqualified warning clear");
    bist_ok = 1; warn_clr = 1; cyc(MA, 0, "R6 warning clear to active");
    cmd_safe = 1;   cyc(MS, 1, "R5 command to fail-safe");
    cmd_init = 1;   cyc(MI, 0, "R6 enter-init from fail-safe");
    wdt_exp = 1;    cyc(MS, 1, "R5 watchdog in init");
    dc_upd = 1;     cyc(MA, 0, "R6 dc update from fail-safe");

    pin_warn = 1;   cyc(MA, 0, "R5 warning with watchdog enabled");
    wdt_off = 1; pin_warn = 1; cyc(MS, 1, "R5 warning with watchdog off");
    wdt_off = 0;
    cmd_init = 1; dc_upd = 1; cyc(MI, 0, "R10 init beats active");

    bist_ok = 0; dc_upd = 1; cyc(MI, 0, "R7 no self-test");
    bist_ok = 1; vs_ok = 0; dc_upd = 1; cyc(MI, 0, "R7 main supply low");
    vs_ok = 1; vdd_up = 0; dc_upd = 1; cyc(MI, 0, "R7 logic supply low");
    vdd_up = 1; cfg_lock = 0; dc_upd = 1; cyc(MI, 0, "R7 not locked");
    emu_ok = 1; pin_act = 1; cyc(MA, 0, "R7 emulation valid and pin request");
    cfg_lock = 1; emu_ok = 0;

    wdt_exp = 1; load_fault = 1; cyc(MI, 0, "R10 init beats fail-safe");
    dc_upd = 1; cmd_safe = 1; cyc(MS, 1, "R10 fail-safe beats active");
    vdd_uv = 1;  cyc(MI, 0, "R3 undervoltage from fail-safe");
    dc_upd = 1;  cyc(MA, 0, "R7");
    vdd_uv = 1;  cyc(MI, 0, "R3 undervoltage from active");
    dc_upd = 1;  cyc(MA, 0, "R7");
    cmd_init = 1; cyc(MI, 0, "R3 enter-init from active");
    dc_upd = 1;  cyc(MA, 0, "R7");

    for (int i = 0; i < 5; i++) begin sync_brk = 1; cyc(MA, 0, "R9 breaks below limit"); end
    sync_brk = 1; cyc(MI, 0, "R3 R9 sixth break");
    pin_act = 1;  cyc(MA, 0, "R7 pin request");
    sync_brk = 1; cyc(MA, 0, "R9 saturated count no request");
    other_frame = 1; cyc(MA, 0, "R9 clear");
    for (int i = 0; i < 3; i++) begin sync_brk = 1; cyc(MA, 0, "R9"); end
    other_frame = 1; cyc(MA, 0, "R9 clear mid run");
    for (int i = 0; i < 5; i++) begin sync_brk = 1; cyc(MA, 0, "R9 count restarted"); end
    sync_brk = 1; cyc(MI, 0, "R9 sixth after clear");

    dc_upd = 1; cyc(MA, 0, "R7");
    bus_alive = 0; err_alive = 0; int_fault = 1; cyc(MO, 0, "R11 dead fault to fail-off");
    bus_alive = 1; err_alive = 1;
    cmd_init = 1; cyc(MO, 0, "R11 enter-init ignored");
    dc_upd = 1;   cyc(MO, 0, "R11 dc update ignored");
    cmd_safe = 1; cyc(MO, 0, "R11 fail-safe command ignored");
    for (int i = 0; i < 6; i++) begin sync_brk = 1; cyc(MO, 0, "R11 breaks ignored"); end
    vdd_uv = 1;   cyc(MI, 0, "R11 undervoltage exits fail-off");
    bus_alive = 0; err_alive = 0; int_fault = 1; cyc(MO, 0, "R11 fail-off from init");
    bus_alive = 1; err_alive = 1; vdd_uv = 1; cyc(MI, 0, "R11");
    dc_upd = 1; cyc(MA, 0, "R7");
    bus_alive = 0; err_alive = 0; int_fault = 1; vdd_uv = 1; cyc(MO, 0, "R10 fail-off beats undervoltage");
    bus_alive = 1; err_alive = 1; vdd_uv = 1; cyc(MI, 0, "R11");
    cyc(MI, 0, "R1 idle stays init");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule